// File: doc/BRIEF.md
# Hierarchical Motion Vector Candidate Controller

This block runs the decision logic of a three-level, coarse-to-fine motion search for one macroblock. It does not touch pixels. It sends search-center commands to an external block-matching engine. It takes back that engine's stream of (vector, cost) results and decides which centers the next level searches. Every result belongs to the command most recently accepted, and the engine marks the last result of each search.

A run starts with a `start` pulse. The controller issues one wide search at the coarse level and keeps the two cheapest results from it. The middle level then runs three local searches. Two are centered on the doubled coarse survivors, and the third on a predictor taken from a neighbouring macroblock's vector. The controller reduces the three middle searches to one winner. At the finest level it runs three local searches, all centered on the doubled middle winner: the frame search, the top-field search and the bottom-field search. The best result of each becomes an output vector. A one-cycle `done` pulse reports the three vectors.

Vector components are two's-complement, 10 bits wide, in half-pel units. The finest level spans -384..383, which is -192.0..+191.5 pels.

Top module: `mv_hier_ctrl`

## Requirements
- R1: After reset the block is idle, with `cmd_valid`, `res_ready` and `done` low. A `start` pulse while idle produces one command with `cmd_level`=0 (coarse), `cmd_kind`=0 (frame) and center (0,0).
- R2: From the coarse results the block keeps the lowest-cost result and the second-lowest-cost result. Costs compare as 16-bit unsigned values. On equal cost the earlier result ranks higher. If only one coarse result arrives, the second survivor is the zero vector.
- R3: Three middle commands (`cmd_level`=1, `cmd_kind`=0) follow, in this order: twice the best coarse vector, twice the second coarse vector, then the predictor. The predictor is the neighbour vector (`nbr_mvx`/`nbr_mvy`, in finest-level units) halved with rounding toward minus infinity when `nbr_valid` was high at `start`, and (0,0) otherwise.
- R4: The middle winner is the lowest-cost result over all results of the three middle searches, with the earliest taken on equal cost. The finest-level center is twice the middle winner.
- R5: The first finest command has `cmd_level`=2 and `cmd_kind`=0. Its lowest-cost result, earliest on equal cost, is driven on `frame_mvx`/`frame_mvy`.
- R6: The frame search is followed by a top-field command (`cmd_kind`=1) and then a bottom-field command (`cmd_kind`=2). Both have `cmd_level`=2 and the same center as the frame search. Each search's best result is driven on `top_mv*` or `bot_mv*`. No command with level 0 or 1 carries a field kind.
- R7: Middle-level centers are clamped to -192..191 in each axis, and finest-level centers to -384..383.
- R8: While `cmd_valid` is high and `cmd_ready` is low, the command stays valid and unchanged. `res_ready` is high only while the block waits for results, and never while `cmd_valid` is high.
- R9: `done` is high for exactly one cycle: the cycle after the last bottom-field result is accepted. In that cycle all three output vectors hold this run's values.
- R10: While a run is in progress, `start` and the neighbour inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run (used only when idle) |
| nbr_valid | input | 1 | Neighbour predictor available |
| nbr_mvx | input | 10 | Neighbour vector x, finest units |
| nbr_mvy | input | 10 | Neighbour vector y, finest units |
| cmd_valid | output | 1 | Search command valid |
| cmd_ready | input | 1 | Engine accepts command |
| cmd_level | output | 2 | 0 coarse, 1 middle, 2 fine |
| cmd_kind | output | 2 | 0 frame, 1 top field, 2 bottom field |
| cmd_cx | output | 10 | Search center x in the level's units |
| cmd_cy | output | 10 | Search center y in the level's units |
| res_valid | input | 1 | Result valid |
| res_ready | output | 1 | Block accepts result |
| res_last | input | 1 | Last result of the current search |
| res_mvx | input | 10 | Result vector x |
| res_mvy | input | 10 | Result vector y |
| res_cost | input | 16 | Result matching cost, unsigned |
| done | output | 1 | One-cycle completion pulse |
| frame_mvx | output | 10 | Frame vector x |
| frame_mvy | output | 10 | Frame vector y |
| top_mvx | output | 10 | Top-field vector x |
| top_mvy | output | 10 | Top-field vector y |
| bot_mvx | output | 10 | Bottom-field vector x |
| bot_mvy | output | 10 | Bottom-field vector y |

## Verification
The assertions check the following on every cycle:
- a stalled command stays valid and unchanged;
- result acceptance never overlaps a pending command;
- every coarse command is centered on zero;
- every issued center lies in its level's clamped range;
- field kinds appear only at the finest level;
- `done` never lasts more than one cycle.

Other behaviour shows only in the bench's scenarios, which compare each command and each output vector with values computed from the streamed results:
- which vectors survive, including ties and single-result searches;
- the halved predictor, and the zero fallback when no neighbour is flagged;
- the doubling before each level;
- the clamping of out-of-range winners;
- the insensitivity to `start` during a run.

// File: rtl/mv_hier_ctrl.sv
module mv_hier_ctrl #(
  parameter int MVW   = 10,
  parameter int CW    = 16,
  parameter int RANGE = 384
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           nbr_valid,
  input  logic [MVW-1:0] nbr_mvx,
  input  logic [MVW-1:0] nbr_mvy,
  output logic           cmd_valid,
  input  logic           cmd_ready,
  output logic [1:0]     cmd_level,
  output logic [1:0]     cmd_kind,
  output logic [MVW-1:0] cmd_cx,
  output logic [MVW-1:0] cmd_cy,
  input  logic           res_valid,
  output logic           res_ready,
  input  logic           res_last,
  input  logic [MVW-1:0] res_mvx,
  input  logic [MVW-1:0] res_mvy,
  input  logic [CW-1:0]  res_cost,
  output logic           done,
  output logic [MVW-1:0] frame_mvx,
  output logic [MVW-1:0] frame_mvy,
  output logic [MVW-1:0] top_mvx,
  output logic [MVW-1:0] top_mvy,
  output logic [MVW-1:0] bot_mvx,
  output logic [MVW-1:0] bot_mvy
);
  localparam int FMIN = -RANGE;
  localparam int FMAX = RANGE - 1;
  localparam int MMIN = -(RANGE / 2);
  localparam int MMAX = RANGE / 2 - 1;

  typedef enum logic [2:0] {IDLE, C_CMD, C_RES, M_CMD, M_RES, F_CMD, F_RES} st_t;
  st_t st;
  logic [1:0] sidx;

  logic           nbv;
  logic [MVW-1:0] nbx, nby;
  logic           b1v, b2v, mv, fv;
  logic [MVW-1:0] b1x, b1y, b2x, b2y, mx, my, fx, fy;
  logic [CW-1:0]  b1c, b2c, mc, fc;

  function automatic int sx(input logic [MVW-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic logic [MVW-1:0] clip(input int v, input int lo, input int hi);
    int r;
    r = (v < lo) ? lo : ((v > hi) ? hi : v);
    return r[MVW-1:0];
  endfunction

  logic acc, take1, take2, mtake, ftake;
  assign acc   = res_valid && res_ready;
  assign take1 = !b1v || (res_cost < b1c);
  assign take2 = !b2v || (res_cost < b2c);
  assign mtake = !mv  || (res_cost < mc);
  assign ftake = !fv  || (res_cost < fc);

  logic [MVW-1:0] fwx, fwy;
  assign fwx = ftake ? res_mvx : fx;
  assign fwy = ftake ? res_mvy : fy;

  logic [MVW-1:0] mcx, mcy, fcx, fcy;
  always_comb begin
    case (sidx)
      2'd0:    begin mcx = clip(2 * sx(b1x), MMIN, MMAX); mcy = clip(2 * sx(b1y), MMIN, MMAX); end
      2'd1:    begin mcx = clip(2 * sx(b2x), MMIN, MMAX); mcy = clip(2 * sx(b2y), MMIN, MMAX); end
      default: begin
        mcx = nbv ? clip(sx(nbx) >>> 1, MMIN, MMAX) : '0;
        mcy = nbv ? clip(sx(nby) >>> 1, MMIN, MMAX) : '0;
      end
    endcase
  end
  assign fcx = clip(2 * sx(mx), FMIN, FMAX);
  assign fcy = clip(2 * sx(my), FMIN, FMAX);

  assign cmd_valid = (st == C_CMD) || (st == M_CMD) || (st == F_CMD);
  assign res_ready = (st == C_RES) || (st == M_RES) || (st == F_RES);
  assign cmd_level = (st == F_CMD) ? 2'd2 : ((st == M_CMD) ? 2'd1 : 2'd0);
  assign cmd_kind  = (st == F_CMD) ? sidx : 2'd0;
  assign cmd_cx    = (st == F_CMD) ? fcx : ((st == M_CMD) ? mcx : '0);
  assign cmd_cy    = (st == F_CMD) ? fcy : ((st == M_CMD) ? mcy : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; sidx <= '0; done <= 1'b0;
      nbv <= 1'b0; nbx <= '0; nby <= '0;
      b1v <= 1'b0; b1x <= '0; b1y <= '0; b1c <= '0;
      b2v <= 1'b0; b2x <= '0; b2y <= '0; b2c <= '0;
      mv <= 1'b0; mx <= '0; my <= '0; mc <= '0;
      fv <= 1'b0; fx <= '0; fy <= '0; fc <= '0;
      frame_mvx <= '0; frame_mvy <= '0;
      top_mvx <= '0; top_mvy <= '0;
      bot_mvx <= '0; bot_mvy <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st <= C_CMD;
          nbv <= nbr_valid; nbx <= nbr_mvx; nby <= nbr_mvy;
          b1v <= 1'b0; b2v <= 1'b0; mv <= 1'b0; fv <= 1'b0;
          b1x <= '0; b1y <= '0; b2x <= '0; b2y <= '0;
        end
        C_CMD: if (cmd_ready) st <= C_RES;
        C_RES: if (acc) begin
          if (take1) begin
            b2v <= b1v; b2x <= b1x; b2y <= b1y; b2c <= b1c;
            b1v <= 1'b1; b1x <= res_mvx; b1y <= res_mvy; b1c <= res_cost;
          end else if (take2) begin
            b2v <= 1'b1; b2x <= res_mvx; b2y <= res_mvy; b2c <= res_cost;
          end
          if (res_last) begin
            st <= M_CMD; sidx <= 2'd0;
          end
        end
        M_CMD: if (cmd_ready) st <= M_RES;
        M_RES: if (acc) begin
          if (mtake) begin
            mv <= 1'b1; mx <= res_mvx; my <= res_mvy; mc <= res_cost;
          end
          if (res_last) begin
            if (sidx == 2'd2) begin
              st <= F_CMD; sidx <= 2'd0;
            end else begin
              st <= M_CMD; sidx <= sidx + 2'd1;
            end
          end
        end
        F_CMD: if (cmd_ready) st <= F_RES;
        F_RES: if (acc) begin
          if (res_last) begin
            fv <= 1'b0;
            case (sidx)
              2'd0:    begin frame_mvx <= fwx; frame_mvy <= fwy; end
              2'd1:    begin top_mvx <= fwx; top_mvy <= fwy; end
              default: begin bot_mvx <= fwx; bot_mvy <= fwy; end
            endcase
            if (sidx == 2'd2) begin
              st <= IDLE; sidx <= 2'd0; done <= 1'b1;
            end else begin
              st <= F_CMD; sidx <= sidx + 2'd1;
            end
          end else if (ftake) begin
            fv <= 1'b1; fx <= res_mvx; fy <= res_mvy; fc <= res_cost;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mv_hier_ctrl_chk.sv
module mv_hier_ctrl_chk #(
  parameter int MVW   = 10,
  parameter int RANGE = 384
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic [1:0]     cmd_level,
  input logic [1:0]     cmd_kind,
  input logic [MVW-1:0] cmd_cx,
  input logic [MVW-1:0] cmd_cy,
  input logic           res_ready,
  input logic           done
);
  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_level) && $stable(cmd_kind)
                                 && $stable(cmd_cx) && $stable(cmd_cy));

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> !cmd_valid);

  p_coarse_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_level == 2'd0 |-> cmd_cx == '0 && cmd_cy == '0 && cmd_kind == 2'd0);

  p_mid_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_level == 2'd1 |->
      int'($signed(cmd_cx)) >= -(RANGE / 2) && int'($signed(cmd_cx)) <= RANGE / 2 - 1 &&
      int'($signed(cmd_cy)) >= -(RANGE / 2) && int'($signed(cmd_cy)) <= RANGE / 2 - 1);

  p_fine_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_level == 2'd2 |->
      int'($signed(cmd_cx)) >= -RANGE && int'($signed(cmd_cx)) <= RANGE - 1 &&
      int'($signed(cmd_cy)) >= -RANGE && int'($signed(cmd_cy)) <= RANGE - 1);

  p_field_fine_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind != 2'd0 |-> cmd_level == 2'd2);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind mv_hier_ctrl mv_hier_ctrl_chk #(.MVW(MVW), .RANGE(RANGE)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_level(cmd_level), .cmd_kind(cmd_kind), .cmd_cx(cmd_cx), .cmd_cy(cmd_cy),
  .res_ready(res_ready), .done(done)
);

// File: tb/mv_hier_ctrl_tb_top.sv
module mv_hier_ctrl_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, nbr_valid, cmd_ready, res_valid, res_last;
  logic [9:0] nbr_mvx, nbr_mvy, res_mvx, res_mvy;
  logic [15:0] res_cost;
  logic cmd_valid, res_ready, done;
  logic [1:0] cmd_level, cmd_kind;
  logic [9:0] cmd_cx, cmd_cy, frame_mvx, frame_mvy, top_mvx, top_mvy, bot_mvx, bot_mvy;

  mv_hier_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .nbr_valid(nbr_valid),
    .nbr_mvx(nbr_mvx), .nbr_mvy(nbr_mvy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_level(cmd_level), .cmd_kind(cmd_kind), .cmd_cx(cmd_cx), .cmd_cy(cmd_cy),
    .res_valid(res_valid), .res_ready(res_ready), .res_last(res_last),
    .res_mvx(res_mvx), .res_mvy(res_mvy), .res_cost(res_cost), .done(done),
    .frame_mvx(frame_mvx), .frame_mvy(frame_mvy), .top_mvx(top_mvx), .top_mvy(top_mvy),
    .bot_mvx(bot_mvx), .bot_mvy(bot_mvy)
  );

  int errors = 0;
  int checks = 0;
  int rx[8], ry[8], rc[8];
  int rn;

  function automatic int clip(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic int s10(logic [9:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(bit ok, string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic take_cmd(output int l, output int k, output int x, output int y);
    bit got = 0;
    bit pend = 0;
    int pl = 0, pk = 0, px = 0, py = 0;
    l = 0; k = 0; x = 0; y = 0;
    while (!got) begin
      @(negedge clk);
      if (pend) begin
        chk(cmd_valid && cmd_level == pl && cmd_kind == pk && s10(cmd_cx) == px && s10(cmd_cy) == py,
            $sformatf("R8 stalled cmd got v%0d l%0d k%0d (%0d,%0d) exp v1 l%0d k%0d (%0d,%0d)",
                      cmd_valid, cmd_level, cmd_kind, s10(cmd_cx), s10(cmd_cy), pl, pk, px, py));
        pend = 0;
      end
      if (cmd_valid) begin
        l = int'(cmd_level); k = int'(cmd_kind); x = s10(cmd_cx); y = s10(cmd_cy);
        if ($urandom % 3 != 0) begin
          cmd_ready = 1'b1; got = 1;
        end else begin
          cmd_ready = 1'b0; pend = 1; pl = l; pk = k; px = x; py = y;
        end
      end else cmd_ready = 1'b0;
    end
    @(posedge clk);
    #1 cmd_ready = 1'b0;
  endtask

  task automatic play();
    for (int i = 0; i < rn; i++) begin
      @(negedge clk);
      res_valid = 1'b1; res_mvx = rx[i][9:0]; res_mvy = ry[i][9:0];
      res_cost = rc[i][15:0]; res_last = (i == rn - 1);
      while (!res_ready) @(negedge clk);
      @(posedge clk);
      if (i == rn - 1 || $urandom % 2 == 0) begin
        @(negedge clk);
        res_valid = 1'b0; res_last = 1'b0;
      end
    end
  endtask

  task automatic fill(int half);
    rn = 1 + int'($urandom % 6);
    for (int i = 0; i < rn; i++) begin
      rx[i] = int'($urandom % (2 * half)) - half;
      ry[i] = int'($urandom % (2 * half)) - half;
      rc[i] = int'($urandom % 5);
      if ($urandom % 8 == 0) rc[i] = 65535;
    end
  endtask

  task automatic run_mb(int mode);
    int nv, nx, ny, l, k, x, y;
    int b1x, b1y, b1c, b2x, b2y, b2c, v1, v2;
    int ex[3], ey[3];
    int mbx, mby, mbc, mvv, fcx, fcy;
    int fo[3][2];
    string tag;
    nv = int'($urandom % 2);
    nx = int'($urandom % 768) - 384;
    ny = int'($urandom % 768) - 384;
    if (mode == 3) begin nv = 1; nx = -5; ny = 7; end
    @(negedge clk);
    nbr_valid = nv[0]; nbr_mvx = nx[9:0]; nbr_mvy = ny[9:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    take_cmd(l, k, x, y);
    chk(l == 0 && k == 0 && x == 0 && y == 0,
        $sformatf("R1 coarse cmd got l%0d k%0d (%0d,%0d) exp l0 k0 (0,0)", l, k, x, y));
    if (mode == 3) begin
      @(negedge clk);
      start = 1'b1; nbr_valid = 1'b0; nbr_mvx = 10'd100; nbr_mvy = 10'd100;
      @(negedge clk);
      start = 1'b0;
    end
    fill(96);
    if (mode == 1) begin
      rn = 2; rx[0] = 120; ry[0] = -150; rc[0] = 1; rx[1] = -150; ry[1] = 95; rc[1] = 2;
    end else if (mode == 4) rn = 1;
    else if (mode == 5) for (int i = 0; i < rn; i++) rc[i] = 2;
    v1 = 0; v2 = 0; b1x = 0; b1y = 0; b1c = 0; b2x = 0; b2y = 0; b2c = 0;
    for (int i = 0; i < rn; i++) begin
      if (!v1 || rc[i] < b1c) begin
        v2 = v1; b2x = b1x; b2y = b1y; b2c = b1c;
        v1 = 1; b1x = rx[i]; b1y = ry[i]; b1c = rc[i];
      end else if (!v2 || rc[i] < b2c) begin
        v2 = 1; b2x = rx[i]; b2y = ry[i]; b2c = rc[i];
      end
    end
    play();
    ex[0] = clip(2 * b1x, -192, 191); ey[0] = clip(2 * b1y, -192, 191);
    ex[1] = clip(2 * b2x, -192, 191); ey[1] = clip(2 * b2y, -192, 191);
    ex[2] = nv ? clip(nx >>> 1, -192, 191) : 0;
    ey[2] = nv ? clip(ny >>> 1, -192, 191) : 0;
    mvv = 0; mbx = 0; mby = 0; mbc = 0;
    for (int s = 0; s < 3; s++) begin
      take_cmd(l, k, x, y);
      tag = (s < 2) ? "R2" : ((mode == 3) ? "R10" : "R3");
      if (mode == 1) tag = {tag, " R7"};
      chk(l == 1 && k == 0 && x == ex[s] && y == ey[s],
          $sformatf("%s middle cmd %0d got l%0d k%0d (%0d,%0d) exp l1 k0 (%0d,%0d)",
                    tag, s, l, k, x, y, ex[s], ey[s]));
      fill(192);
      if (mode == 2 && s == 0) begin rx[0] = 200; ry[0] = -250; rc[0] = 0; end
      for (int i = 0; i < rn; i++)
        if (!mvv || rc[i] < mbc) begin mvv = 1; mbx = rx[i]; mby = ry[i]; mbc = rc[i]; end
      play();
    end
    fcx = clip(2 * mbx, -384, 383); fcy = clip(2 * mby, -384, 383);
    for (int s = 0; s < 3; s++) begin
      int bx, by, bc, bv;
      take_cmd(l, k, x, y);
      tag = (s == 0) ? "R4" : "R6";
      if (mode == 2) tag = {tag, " R7"};
      chk(l == 2 && k == s && x == fcx && y == fcy,
          $sformatf("%s fine cmd %0d got l%0d k%0d (%0d,%0d) exp l2 k%0d (%0d,%0d)",
                    tag, s, l, k, x, y, s, fcx, fcy));
      fill(384);
      bv = 0; bx = 0; by = 0; bc = 0;
      for (int i = 0; i < rn; i++)
        if (!bv || rc[i] < bc) begin bv = 1; bx = rx[i]; by = ry[i]; bc = rc[i]; end
      fo[s][0] = bx; fo[s][1] = by;
      if (s < 2) play();
      else begin
        play();
        chk(done == 1'b1, $sformatf("R9 done after last result got %0d exp 1", done));
        chk(s10(frame_mvx) == fo[0][0] && s10(frame_mvy) == fo[0][1],
            $sformatf("R5 frame mv got (%0d,%0d) exp (%0d,%0d)",
                      s10(frame_mvx), s10(frame_mvy), fo[0][0], fo[0][1]));
        chk(s10(top_mvx) == fo[1][0] && s10(top_mvy) == fo[1][1],
            $sformatf("R6 top mv got (%0d,%0d) exp (%0d,%0d)",
                      s10(top_mvx), s10(top_mvy), fo[1][0], fo[1][1]));
        chk(s10(bot_mvx) == fo[2][0] && s10(bot_mvy) == fo[2][1],
            $sformatf("R6 bottom mv got (%0d,%0d) exp (%0d,%0d)",
                      s10(bot_mvx), s10(bot_mvy), fo[2][0], fo[2][1]));
        @(negedge clk);
        chk(done == 1'b0 && cmd_valid == 1'b0,
            $sformatf("R9 done one cycle got done%0d cmd%0d exp 0 0", done, cmd_valid));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog: run hung, got no completion exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; nbr_valid = 1'b0; nbr_mvx = '0; nbr_mvy = '0;
    cmd_ready = 1'b0; res_valid = 1'b0; res_last = 1'b0;
    res_mvx = '0; res_mvy = '0; res_cost = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmd_valid && !res_ready && !done,
        $sformatf("R1 reset idle got cmd%0d res%0d done%0d exp 0 0 0", cmd_valid, res_ready, done));
    for (int m = 1; m <= 5; m++) run_mb(m);
    for (int n = 0; n < 40; n++) run_mb(0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule